// File: doc/BRIEF.md
# Rotational Sector Position Generator

This block derives sector timing for a head-per-track rotating store. A single-cycle word strobe marks each word time passing under the heads. The block tracks where the heads are within one revolution. A revolution is an overhead gap of 5 word times followed by a fixed number of 64-word sectors.

From that position the block presents the following:
- a sector count naming the next sector to arrive;
- a phase flag that warns when the current sector is about to end;
- a start-of-sector pulse;
- a latched flag recording that the track origin has passed since software last cleared it.

A mode input picks between two geometries. Disk geometry has 90 sectors per track. Drum geometry has 32 sectors per track. In drum mode the two diagnostic skip outputs (origin seen and phase clear) are held inactive.

Top module: `rot_sector_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the position returns to word 0 of the gap and the origin latch clears. After reset, `sec_cnt` is 0, `sec_phase` is 0, `sec_start` is 0 and `origin_seen` is 0.
- R2: The position moves by exactly one word on each clock edge where `word_stb` is 1. With `word_stb` at 0, `sec_cnt`, `sec_phase`, `phase_ok` and `origin_seen` keep their values and `sec_start` stays 0.
- R3: Position p runs from 0 to L-1 and then wraps to 0, where L = 64*N + 5. N is 90 in disk mode (`drum_mode`=0) and 32 in drum mode (`drum_mode`=1).
- R4: In disk mode `sec_cnt` is 0 for p from 0 to 5. Otherwise it is (p-5)/64 + 1, using integer division, so it reads 90 throughout the last sector.
- R5: In drum mode `sec_cnt` is 0 for p from 0 to 5. Otherwise it is (p-5)/64, so it stays 0 through the whole first sector and peaks at 31.
- R6: `sec_phase` is 1 exactly when p >= 5 and (p-5) mod 64 >= 61, that is, during the last 3 words of each sector. It is 0 during the gap.
- R7: `sec_start` is 1 for exactly the one clock following a strobe edge that moves p onto a sector's first word (p = 5 + 64*k). It is 0 at all other times.
- R8: `origin_seen` sets on the strobe edge where p wraps from L-1 to 0, and clears on an edge where `org_clr` is 1. When both happen on the same edge, the clear wins.
- R9: In drum mode `origin_seen` and `phase_ok` are 0. In disk mode `phase_ok` is the inverse of `sec_phase`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_stb | input | 1 | One-cycle pulse per word time |
| drum_mode | input | 1 | 0 = disk geometry (90 sectors), 1 = drum geometry (32 sectors) |
| org_clr | input | 1 | Clears the origin-seen latch |
| sec_cnt | output | 7 | Next-sector count |
| sec_phase | output | 1 | High in the last 3 words of a sector |
| phase_ok | output | 1 | Diagnostic: sector still accessible (disk mode only) |
| origin_seen | output | 1 | Diagnostic: track origin passed since the last clear (disk mode only) |
| sec_start | output | 1 | One-clock pulse at the first word of each sector |

## Verification
All position state is registered on the edge that consumes a strobe. `sec_cnt`, `sec_phase` and `phase_ok` are decoded from that state without further registers, so they are valid right after that same edge. `sec_start` and `origin_seen` are registered on the same edge, so they are also due zero cycles after the strobe edge, and `sec_start` drops one clock later. The bench drives strobes and clears on the falling edge and samples 1 ns after each rising edge. It compares every output against a position model that advances by one word per strobe and computes counts with integer division and modulo.

// File: rtl/rsp_pkg.sv
// Shared geometry constants and the geometry selector type for the
// rotational sector position generator.
package rsp_pkg;
    localparam int RSP_WORDS_PER_SEC = 64;
    localparam int RSP_GAP_WORDS     = 5;
    localparam int RSP_DISK_SECS     = 90;
    localparam int RSP_DRUM_SECS     = 32;
    localparam int RSP_PHASE_WORDS   = 3;

    typedef enum logic {
        GEO_DISK = 1'b0,
        GEO_DRUM = 1'b1
    } geo_e;
endpackage

// File: rtl/rsp_word_ctr.sv
// Revolution position counter.
// Tracks the gap word index, the word offset within a sector and the sector
// index, all advanced by one word per strobe.
// Assumes: word_stb is a one-cycle pulse; geo changes only while idle.
// Produces: a combinational wrap strobe (on the edge that returns to the
// gap) and a registered start-of-sector pulse.
module rsp_word_ctr
    import rsp_pkg::*;
#(
    parameter int WORDS     = RSP_WORDS_PER_SEC,
    parameter int GAP       = RSP_GAP_WORDS,
    parameter int DISK_SECS = RSP_DISK_SECS,
    parameter int DRUM_SECS = RSP_DRUM_SECS,
    localparam int OFS_W    = $clog2(WORDS),
    localparam int SIDX_W   = $clog2(DISK_SECS),
    localparam int GAP_W    = (GAP > 1) ? $clog2(GAP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_stb,
    input  geo_e              geo,
    output logic              in_gap,
    output logic [OFS_W-1:0]  wofs,
    output logic [SIDX_W-1:0] sidx,
    output logic              wrap,
    output logic              sos
);
    localparam logic [OFS_W-1:0]  LAST_OFS  = OFS_W'(WORDS - 1);
    localparam logic [GAP_W-1:0]  LAST_GAP  = GAP_W'(GAP - 1);
    localparam logic [SIDX_W-1:0] DISK_LAST = SIDX_W'(DISK_SECS - 1);
    localparam logic [SIDX_W-1:0] DRUM_LAST = SIDX_W'(DRUM_SECS - 1);

    logic [GAP_W-1:0]  gap_cnt;
    logic [SIDX_W-1:0] sec_last;
    logic              at_last;
    logic              gap_done;
    logic              ofs_done;

    // Pick the last sector index for the active geometry.
    always_comb begin
        sec_last = (geo == GEO_DRUM) ? DRUM_LAST : DISK_LAST;
    end

    // Decode the end-of-gap, end-of-sector and end-of-revolution conditions.
    always_comb begin
        gap_done = in_gap && (gap_cnt == LAST_GAP);
        ofs_done = !in_gap && (wofs == LAST_OFS);
        at_last  = ofs_done && (sidx >= sec_last);
        wrap     = word_stb && at_last;
    end

    // Advance the position by one word on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_gap  <= 1'b1;
            gap_cnt <= '0;
            wofs    <= '0;
            sidx    <= '0;
        end else if (word_stb) begin
            if (in_gap) begin
                if (gap_done) begin
                    in_gap <= 1'b0;
                    wofs   <= '0;
                    sidx   <= '0;
                end else begin
                    gap_cnt <= gap_cnt + 1'b1;
                end
            end else if (at_last) begin
                in_gap  <= 1'b1;
                gap_cnt <= '0;
                wofs    <= '0;
            end else if (ofs_done) begin
                wofs <= '0;
                sidx <= sidx + 1'b1;
            end else begin
                wofs <= wofs + 1'b1;
            end
        end
    end

    // Pulse for one clock when the position lands on a sector's first word.
    always_ff @(posedge clk) begin
        if (!rst_n) sos <= 1'b0;
        else        sos <= word_stb && (gap_done || (ofs_done && !at_last));
    end

    // R2: without a strobe the position does not move
    p_hold_no_stb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !word_stb |=> ($stable(in_gap) && $stable(wofs) && $stable(sidx) && $stable(gap_cnt)));

    // R3: the gap index never reaches the gap length
    p_gap_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_gap |-> (gap_cnt <= LAST_GAP));

    // R3: a wrap returns the position to the first gap word
    p_wrap_to_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (in_gap && gap_cnt == '0));

    // R7: the start-of-sector pulse lasts one clock and follows a strobe
    p_sos_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sos |=> !sos);
    p_sos_after_stb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sos |-> (!in_gap && wofs == '0));
endmodule

// File: rtl/rsp_sector_map.sv
// Sector count and phase decoder.
// Maps the registered position to the next-sector count and the
// near-end-of-sector phase flag.
// Assumes: the inputs come straight from rsp_word_ctr registers.
// Output is combinational, so results are valid in the cycle after the
// strobe edge.
module rsp_sector_map
    import rsp_pkg::*;
#(
    parameter int WORDS       = RSP_WORDS_PER_SEC,
    parameter int DISK_SECS   = RSP_DISK_SECS,
    parameter int PHASE_WORDS = RSP_PHASE_WORDS,
    localparam int OFS_W      = $clog2(WORDS),
    localparam int SIDX_W     = $clog2(DISK_SECS),
    localparam int CNT_W      = $clog2(DISK_SECS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  geo_e              geo,
    input  logic              in_gap,
    input  logic [OFS_W-1:0]  wofs,
    input  logic [SIDX_W-1:0] sidx,
    output logic [CNT_W-1:0]  sec_cnt,
    output logic              phase
);
    localparam logic [OFS_W-1:0] PHASE_FROM = OFS_W'(WORDS - PHASE_WORDS);
    localparam logic [CNT_W-1:0] CNT_MAX    = CNT_W'(DISK_SECS);

    logic pre_first;

    // Count is 0 through the gap and the first word of sector 0.
    always_comb begin
        pre_first = in_gap || (sidx == '0 && wofs == '0);
        if (pre_first)
            sec_cnt = '0;
        else if (geo == GEO_DISK)
            sec_cnt = CNT_W'(sidx) + 1'b1;
        else
            sec_cnt = CNT_W'(sidx);
    end

    // Phase flag covers the final words of every sector.
    always_comb begin
        phase = !in_gap && (wofs >= PHASE_FROM);
    end

    // R4: the count never exceeds the disk sector total
    p_cnt_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sec_cnt <= CNT_MAX);

    // R6: the phase flag is never set on the first word of a sector
    p_phase_not_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_gap && wofs == '0) |-> !phase);
endmodule

// File: rtl/rsp_origin_latch.sv
// Track origin latch and diagnostic skip gating.
// Sets on a revolution wrap and clears on a clear pulse, with the clear
// taking priority. Both diagnostic outputs are forced low in drum geometry.
// Assumes: wrap is a combinational strobe valid on the wrapping edge.
module rsp_origin_latch
    import rsp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  geo_e geo,
    input  logic wrap,
    input  logic clr,
    input  logic phase,
    output logic origin_seen,
    output logic phase_ok
);
    logic org_q;

    // Hold the origin-passed state until software clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)    org_q <= 1'b0;
        else if (clr)  org_q <= 1'b0;
        else if (wrap) org_q <= 1'b1;
    end

    // Gate the diagnostic outputs by geometry.
    always_comb begin
        origin_seen = org_q && (geo == GEO_DISK);
        phase_ok    = !phase && (geo == GEO_DISK);
    end

    // R8: the latch only rises on an edge where the revolution wrapped
    p_org_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(org_q) |-> $past(wrap));

    // R8: a clear always empties the latch on the next edge
    p_org_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !org_q);
endmodule

// File: rtl/rot_sector_timer.sv
// Rotational sector position generator, top level.
// Converts a word-time strobe into the next-sector count, sector phase flag,
// start-of-sector pulse and origin diagnostics for disk or drum geometry.
// Assumes: drum_mode is static during operation; all inputs are synchronous
// to clk.
module rot_sector_timer
    import rsp_pkg::*;
#(
    parameter int WORDS       = RSP_WORDS_PER_SEC,
    parameter int GAP         = RSP_GAP_WORDS,
    parameter int DISK_SECS   = RSP_DISK_SECS,
    parameter int DRUM_SECS   = RSP_DRUM_SECS,
    parameter int PHASE_WORDS = RSP_PHASE_WORDS,
    localparam int OFS_W      = $clog2(WORDS),
    localparam int SIDX_W     = $clog2(DISK_SECS),
    localparam int CNT_W      = $clog2(DISK_SECS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_stb,
    input  logic             drum_mode,
    input  logic             org_clr,
    output logic [CNT_W-1:0] sec_cnt,
    output logic             sec_phase,
    output logic             phase_ok,
    output logic             origin_seen,
    output logic             sec_start
);
    geo_e              geo;
    logic              in_gap;
    logic [OFS_W-1:0]  wofs;
    logic [SIDX_W-1:0] sidx;
    logic              wrap;

    // Translate the mode pin into the geometry type.
    always_comb begin
        geo = drum_mode ? GEO_DRUM : GEO_DISK;
    end

    rsp_word_ctr #(
        .WORDS(WORDS), .GAP(GAP), .DISK_SECS(DISK_SECS), .DRUM_SECS(DRUM_SECS)
    ) u_ctr (
        .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .geo(geo),
        .in_gap(in_gap), .wofs(wofs), .sidx(sidx), .wrap(wrap), .sos(sec_start)
    );

    rsp_sector_map #(
        .WORDS(WORDS), .DISK_SECS(DISK_SECS), .PHASE_WORDS(PHASE_WORDS)
    ) u_map (
        .clk(clk), .rst_n(rst_n), .geo(geo), .in_gap(in_gap), .wofs(wofs),
        .sidx(sidx), .sec_cnt(sec_cnt), .phase(sec_phase)
    );

    rsp_origin_latch u_org (
        .clk(clk), .rst_n(rst_n), .geo(geo), .wrap(wrap), .clr(org_clr),
        .phase(sec_phase), .origin_seen(origin_seen), .phase_ok(phase_ok)
    );

    // R9: drum geometry keeps both diagnostic outputs quiet
    p_drum_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        drum_mode |-> (!origin_seen && !phase_ok));

    // R5: drum geometry never reports a count beyond its last sector
    p_drum_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        drum_mode |-> (sec_cnt < CNT_W'(DRUM_SECS)));
endmodule

// File: tb/sim_rot_sector_timer.sv
`timescale 1ns/1ps
module sim_rot_sector_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       word_stb = 1'b0;
    logic       drum_mode = 1'b0;
    logic       org_clr = 1'b0;
    logic [6:0] sec_cnt;
    logic       sec_phase, phase_ok, origin_seen, sec_start;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // model state
    int  pos = 0;
    bit  org = 0;
    bit  sos_e = 0;

    rot_sector_timer u0 (
        .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .drum_mode(drum_mode),
        .org_clr(org_clr), .sec_cnt(sec_cnt), .sec_phase(sec_phase),
        .phase_ok(phase_ok), .origin_seen(origin_seen), .sec_start(sec_start)
    );

    always #5 clk = ~clk;

    function automatic int rev_len();
        return 64 * (drum_mode ? 32 : 90) + 5;
    endfunction

    function automatic int exp_cnt();
        if (pos <= 5) return 0;
        return (pos - 5) / 64 + (drum_mode ? 0 : 1);
    endfunction

    function automatic bit exp_phase();
        return (pos >= 5) && (((pos - 5) % 64) >= 61);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s at pos %0d: actual=%0d expected=%0d", req, what, pos, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(drum_mode ? {req, "/R5"} : {req, "/R4"}, "sec_cnt", sec_cnt, exp_cnt());
        check({req, "/R6"}, "sec_phase", sec_phase, exp_phase());
        check({req, "/R7"}, "sec_start", sec_start, sos_e);
        check({req, "/R8"}, "origin_seen", origin_seen, org && !drum_mode);
        check({req, "/R9"}, "phase_ok", phase_ok, !drum_mode && !exp_phase());
    endtask

    // One clock: drive at falling edge, sample 1 ns after rising edge.
    task automatic step(input bit stb, input bit clr, input string req);
        @(negedge clk);
        word_stb = stb;
        org_clr  = clr;
        @(posedge clk);
        #1;
        word_stb = 1'b0;
        org_clr  = 1'b0;
        if (stb) pos = (pos + 1) % rev_len();
        if (clr) org = 0;
        else if (stb && pos == 0) org = 1;
        sos_e = stb && (pos >= 5) && (((pos - 5) % 64) == 0);
        check_all(req);
    endtask

    task automatic t_reset(input bit drum);
        @(negedge clk);
        drum_mode = drum;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        pos = 0; org = 0; sos_e = 0;
        check_all("R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check_all("R1");
    endtask

    task automatic t_disk_sweep();
        t_reset(1'b0);
        for (int i = 0; i < rev_len() + 140; i++) step(1'b1, 1'b0, "R3");
    endtask

    task automatic t_hold();
        for (int i = 0; i < 60; i++) step(1'b1, 1'b0, "R2");
        for (int i = 0; i < 12; i++) step(1'b0, 1'b0, "R2");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R2");
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, "R2");
    endtask

    task automatic t_origin();
        step(1'b0, 1'b1, "R8");
        check("R8", "origin cleared", origin_seen, 0);
        while (pos != 0) step(1'b1, 1'b0, "R8");
        check("R8", "origin set at wrap", origin_seen, 1);
        step(1'b0, 1'b1, "R8");
        while (pos != rev_len() - 1) step(1'b1, 1'b0, "R8");
        step(1'b1, 1'b1, "R8");
        check("R8", "clear wins over wrap", origin_seen, 0);
        check("R3", "wrapped position count", sec_cnt, 0);
    endtask

    task automatic t_drum_sweep();
        t_reset(1'b1);
        for (int i = 0; i < 2 * rev_len() + 10; i++) step(1'b1, 1'b0, "R5");
        step(1'b0, 1'b1, "R9");
    endtask

    initial begin
        t_disk_sweep();
        t_hold();
        t_origin();
        t_drum_sweep();
        t_reset(1'b0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_900_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule